// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block sits on the host side of a four-channel, 12-bit serial converter whose internal shift register is clocked by the logical OR of its chip-select and serial-clock pins. A single request carries a channel number and a straight-binary code. The block frames them into one serial word, shifts the word out with chip-select low, raises chip-select while the serial clock is still high, and then drops the load strobe for a short pulse so that the selected channel register takes the new code. Busy and done handshakes report progress.

The serial clock half-period comes from a configuration input counted in system clocks and is captured when a request is accepted. A separate request drives the converter's active-low reset pin for a fixed pulse and, at the same edge, captures the level that selects the reset value. A reset pulse can overlap a frame that is being shifted without disturbing it. Throughout, the edge order of the pins keeps the OR-combined shift clock free of stray edges and never lets the shift register move while the load strobe is low.

Top module: `dac_frame_host`

## Requirements
- R1: After reset, dac_cs_n, dac_sclk, dac_load_n and dac_reset_n are 1, and busy and done are 0.
- R2: Each frame produces exactly 16 rising edges of (dac_cs_n OR dac_sclk); the bits sampled at those edges are, first to last, channel bit 1, channel bit 0, two zero bits, then code bit 11 down to code bit 0; dac_sdi changes only while dac_sclk is low.
- R3: dac_cs_n rises only in a cycle where dac_sclk is high and was high in the cycle before.
- R4: dac_load_n is low only while dac_cs_n and dac_sclk are both high and steady, so no shift edge occurs during a load pulse; while busy is 0 the pins dac_cs_n, dac_sclk and dac_load_n are all high.
- R5: Channel values 0, 1, 2 and 3 on req_chan select converter registers A, B, C and D; only the selected register takes the code.
- R6: With h = cfg_half, or 1 when cfg_half is 0, the clock is low for h and high for h system clocks per bit, busy stays high for exactly 34*h+LOAD_CYC cycles, and a change of cfg_half during a frame has no effect on that frame.
- R7: req_valid is taken only while busy is 0; a request made while busy is dropped and starts no later frame.
- R8: done is a single-cycle pulse, raised exactly once per frame in the cycle dac_load_n returns high.
- R9: A rst_req while no reset pulse is running drives dac_reset_n low for exactly RST_CYC cycles; dac_rstsel takes rst_level_sel at that edge and holds it until the pulse ends; the converter then resets every register to 0x800 when dac_rstsel is 1, else to 0x000.
- R10: A reset pulse that occurs while a frame is being shifted leaves that frame intact: after the frame, the addressed register holds the new code and all others hold the reset value.
- R11: A load pulse lasts LOAD_CYC cycles, at least two, and follows the rise of dac_cs_n by h cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| cfg_half | input | DIV_W | Serial clock half-period in system clocks (0 acts as 1) |
| req_valid | input | 1 | Write request, taken when not busy |
| req_chan | input | 2 | Target channel, 0..3 for A..D |
| req_code | input | CODE_W | Straight-binary code to write |
| rst_req | input | 1 | Request for a converter reset pulse |
| rst_level_sel | input | 1 | Reset value select: 1 gives mid-scale, 0 gives zero |
| busy | output | 1 | A frame or its load pulse is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| dac_cs_n | output | 1 | Converter chip-select, active low |
| dac_sclk | output | 1 | Converter serial clock, idles high |
| dac_sdi | output | 1 | Converter serial data |
| dac_load_n | output | 1 | Converter load strobe, active low |
| dac_reset_n | output | 1 | Converter reset, active low |
| dac_rstsel | output | 1 | Converter reset value select level |

## Verification
A converter reset pulse and a frame in its shifting phase can run in the same cycles, since the two share no state in the block. The bench forks a reset request about twenty cycles into a frame with a half-period of two, so the pulse lies entirely inside the shift phase, and then requires that the behavioural converter model shows every other channel at the reset value while the addressed channel carries the new code. The model rebuilds the shift register from the OR of chip-select and clock on every cycle, so any stray edge caused by the overlap shows up as a wrong channel or code.

// File: rtl/dfh_pkg.sv
package dfh_pkg;
   localparam int CHAN_W = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_CLKLO,
      ST_CLKHI,
      ST_CSUP,
      ST_LOAD
   } seq_st_t;
endpackage

// File: rtl/dfh_tick.sv
module dfh_tick #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] lim,
   output logic             last
);
   logic [CNT_W-1:0] cnt;

   assign last = (cnt == lim);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr || last)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> cnt <= lim)
      else $error("phase counter beyond limit"); // R6
endmodule

// File: rtl/dfh_frame.sv
module dfh_frame #(
   parameter int CHAN_W = 2,
   parameter int PAD_W  = 2,
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [CHAN_W-1:0] chan,
   input  logic [CODE_W-1:0] code,
   output logic              msb
);
   localparam int FRAME_W = CHAN_W + PAD_W + CODE_W;

   logic [FRAME_W-1:0] word;
   logic [FRAME_W-1:0] sr;

   generate
      if (PAD_W > 0) begin : g_pad
         assign word = {chan, {PAD_W{1'b0}}, code};
      end else begin : g_nopad
         assign word = {chan, code};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         sr <= '0;
      else if (load)
         sr <= word;
      else if (shift)
         sr <= {sr[FRAME_W-2:0], 1'b0};
   end

   assign msb = sr[FRAME_W-1];

   AST_NO_LOAD_AND_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift))
      else $error("frame load and shift together"); // R2
endmodule

// File: rtl/dfh_rstgen.sv
module dfh_rstgen #(
   parameter int RST_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic level,
   output logic reset_n,
   output logic rstsel
);
   localparam int CW = $clog2(RST_CYC + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nx;

   always_comb begin
      cnt_nx = cnt;
      if (cnt != '0)
         cnt_nx = cnt - 1'b1;
      else if (req)
         cnt_nx = CW'(RST_CYC);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         reset_n <= 1'b1;
         rstsel  <= 1'b0;
      end else begin
         cnt     <= cnt_nx;
         reset_n <= (cnt_nx == '0);
         if (cnt == '0)
            rstsel <= level;
      end
   end

   AST_RSTSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!reset_n && !$past(reset_n)) |-> $stable(rstsel))
      else $error("reset select moved during pulse"); // R9
   AST_RST_FALL_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reset_n) |-> $past(req))
      else $error("reset pulse without request"); // R9
endmodule

// File: rtl/dac_frame_host.sv
module dac_frame_host
   import dfh_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int CODE_W   = 12,
   parameter int PAD_W    = 2,
   parameter int LOAD_CYC = 2,
   parameter int RST_CYC  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_half,
   input  logic              req_valid,
   input  logic [CHAN_W-1:0] req_chan,
   input  logic [CODE_W-1:0] req_code,
   input  logic              rst_req,
   input  logic              rst_level_sel,
   output logic              busy,
   output logic              done,
   output logic              dac_cs_n,
   output logic              dac_sclk,
   output logic              dac_sdi,
   output logic              dac_load_n,
   output logic              dac_reset_n,
   output logic              dac_rstsel
);
   localparam int FRAME_W = CHAN_W + PAD_W + CODE_W;
   localparam int BIT_W   = $clog2(FRAME_W);
   localparam int LW      = $clog2(LOAD_CYC + 1);
   localparam int CNT_W   = (DIV_W > LW) ? DIV_W : LW;

   generate
      if (LOAD_CYC < 2) begin : g_bad_load
         $error("LOAD_CYC must be at least 2");
      end
      if (RST_CYC < 1) begin : g_bad_rst
         $error("RST_CYC must be at least 1");
      end
      if (DIV_W < 1 || CODE_W < 1 || PAD_W < 0) begin : g_bad_width
         $error("bad width parameter");
      end
   endgenerate

   seq_st_t          state;
   logic [BIT_W-1:0] bit_cnt;
   logic [CNT_W-1:0] half_lim;
   logic [CNT_W-1:0] lim;
   logic             last;
   logic             accept;
   logic             shift;

   assign accept = (state == ST_IDLE) && req_valid;
   assign shift  = (state == ST_CLKHI) && last && (bit_cnt != BIT_W'(FRAME_W - 1));
   assign lim    = (state == ST_LOAD) ? CNT_W'(LOAD_CYC - 1) : half_lim;
   assign busy   = (state != ST_IDLE);

   dfh_tick #(.CNT_W(CNT_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state == ST_IDLE),
      .lim   (lim),
      .last  (last)
   );

   dfh_frame #(.CHAN_W(CHAN_W), .PAD_W(PAD_W), .CODE_W(CODE_W)) u_frame (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .shift (shift),
      .chan  (req_chan),
      .code  (req_code),
      .msb   (dac_sdi)
   );

   dfh_rstgen #(.RST_CYC(RST_CYC)) u_rst (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (rst_req),
      .level   (rst_level_sel),
      .reset_n (dac_reset_n),
      .rstsel  (dac_rstsel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         half_lim   <= '0;
         dac_cs_n   <= 1'b1;
         dac_sclk   <= 1'b1;
         dac_load_n <= 1'b1;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state    <= ST_SETUP;
                  dac_cs_n <= 1'b0;
                  bit_cnt  <= '0;
                  half_lim <= (cfg_half == '0) ? '0 : CNT_W'(cfg_half - 1'b1);
               end
            end
            ST_SETUP: begin
               if (last) begin
                  dac_sclk <= 1'b0;
                  state    <= ST_CLKLO;
               end
            end
            ST_CLKLO: begin
               if (last) begin
                  dac_sclk <= 1'b1;
                  state    <= ST_CLKHI;
               end
            end
            ST_CLKHI: begin
               if (last) begin
                  if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
                     dac_cs_n <= 1'b1;
                     state    <= ST_CSUP;
                  end else begin
                     dac_sclk <= 1'b0;
                     bit_cnt  <= bit_cnt + 1'b1;
                     state    <= ST_CLKLO;
                  end
               end
            end
            ST_CSUP: begin
               if (last) begin
                  dac_load_n <= 1'b0;
                  state      <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (last) begin
                  dac_load_n <= 1'b1;
                  done       <= 1'b1;
                  state      <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_CS_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_cs_n) |-> (dac_sclk && $past(dac_sclk)))
      else $error("chip-select rose with clock low"); // R3
   AST_NO_SHIFT_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_load_n |-> (dac_cs_n && dac_sclk && $past(dac_cs_n) && $past(dac_sclk)))
      else $error("shift possible during load"); // R4
   AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dac_cs_n && dac_sclk && dac_load_n))
      else $error("bus not idle while not busy"); // R4
   AST_SDI_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_cs_n && !$past(dac_cs_n) && (dac_sdi != $past(dac_sdi))) |-> !dac_sclk)
      else $error("data moved with clock high"); // R2
   AST_LOAD_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_load_n) |-> !$past(dac_load_n, 2))
      else $error("load pulse too short"); // R11
   AST_DONE_AT_LOAD_END: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (dac_load_n && !$past(dac_load_n)))
      else $error("done not at end of load"); // R8
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle"); // R8
   AST_HALF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(half_lim))
      else $error("half-period changed mid-frame"); // R6
endmodule

// File: tb/dac_frame_host_test.sv
module dac_frame_host_test;
   localparam int DIV_W    = 8;
   localparam int LOAD_CYC = 2;
   localparam int RST_CYC  = 4;
   localparam int WD_LIMIT = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] cfg_half = 8'd1;
   logic             req_valid = 1'b0;
   logic [1:0]       req_chan = 2'd0;
   logic [11:0]      req_code = 12'd0;
   logic             rst_req = 1'b0;
   logic             rst_level_sel = 1'b0;
   logic busy, done, dac_cs_n, dac_sclk, dac_sdi, dac_load_n, dac_reset_n, dac_rstsel;

   always #10 clk = ~clk;

   dac_frame_host #(.DIV_W(DIV_W), .LOAD_CYC(LOAD_CYC), .RST_CYC(RST_CYC)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .req_valid(req_valid),
      .req_chan(req_chan), .req_code(req_code), .rst_req(rst_req),
      .rst_level_sel(rst_level_sel), .busy(busy), .done(done),
      .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi),
      .dac_load_n(dac_load_n), .dac_reset_n(dac_reset_n), .dac_rstsel(dac_rstsel)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   // behavioural converter model state
   logic [15:0] m_sr = '0;
   logic [11:0] m_reg [4];
   logic [11:0] exp_reg [4];
   logic or_prev = 1'b1, cs_prev = 1'b1, load_prev = 1'b1;
   int edges = 0, busy_cyc = 0, done_cnt = 0, low_cyc = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_reg[i] = '0;
         exp_reg[i] = '0;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         logic or_now;
         or_now = dac_cs_n | dac_sclk;
         if (or_now && !or_prev) begin
            chk(dac_load_n == 1'b1, "R4", dac_load_n, 1);
            m_sr = {m_sr[14:0], dac_sdi};
            edges++;
         end
         if (dac_cs_n && !cs_prev)
            chk(dac_sclk == 1'b1, "R3", dac_sclk, 1);
         if (!dac_reset_n) begin
            low_cyc++;
            for (int i = 0; i < 4; i++) m_reg[i] = dac_rstsel ? 12'h800 : 12'h000;
         end else if (!dac_load_n) begin
            chk(m_sr[13:12] == 2'b00, "R2", m_sr[13:12], 0);
            m_reg[m_sr[15:14]] = m_sr[11:0];
         end
         if (busy) busy_cyc++;
         if (done) begin
            done_cnt++;
            chk(dac_load_n && !load_prev, "R8", {dac_load_n, load_prev}, 2);
         end
         if (!busy)
            chk(dac_cs_n && dac_sclk && dac_load_n, "R4", {dac_cs_n, dac_sclk, dac_load_n}, 7);
         or_prev = or_now;
         cs_prev = dac_cs_n;
         load_prev = dac_load_n;
      end
   end

   task automatic send(input logic [1:0] ch, input logic [11:0] code, input int half);
      int h;
      int d0;
      h = (half == 0) ? 1 : half;
      @(negedge clk); #1;
      edges = 0;
      busy_cyc = 0;
      d0 = done_cnt;
      cfg_half = DIV_W'(half);
      req_chan = ch;
      req_code = code;
      req_valid = 1'b1;
      @(negedge clk); #1;
      req_valid = 1'b0;
      do begin
         @(negedge clk); #1;
      end while (!done);
      exp_reg[ch] = code;
      chk(edges == 16, "R2", edges, 16);
      chk(busy_cyc == 34 * h + LOAD_CYC, "R6", busy_cyc, 34 * h + LOAD_CYC);
      chk(m_reg[ch] == code, "R5", m_reg[ch], code);
      for (int i = 0; i < 4; i++)
         chk(m_reg[i] == exp_reg[i], "R5", m_reg[i], exp_reg[i]);
      repeat (3) @(negedge clk);
      #1;
      chk(done_cnt - d0 == 1, "R8", done_cnt - d0, 1);
      chk(!busy, "R7", busy, 0);
   endtask

   task automatic issue_reset(input logic level, input bit flip);
      logic [11:0] rv;
      rv = level ? 12'h800 : 12'h000;
      @(negedge clk); #1;
      low_cyc = 0;
      rst_level_sel = level;
      rst_req = 1'b1;
      @(negedge clk); #1;
      rst_req = 1'b0;
      if (flip) rst_level_sel = ~level;
      @(negedge clk); #1;
      chk(dac_rstsel == level, "R9", dac_rstsel, level);
      chk(!dac_reset_n, "R9", dac_reset_n, 0);
      repeat (RST_CYC + 2) @(negedge clk);
      #1;
      for (int i = 0; i < 4; i++) exp_reg[i] = rv;
      chk(low_cyc == RST_CYC, "R9", low_cyc, RST_CYC);
      for (int i = 0; i < 4; i++)
         chk(m_reg[i] == rv, "R9", m_reg[i], rv);
      rst_level_sel = level;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1;
      // R1 reset state while rst_n low
      chk(dac_cs_n && dac_sclk && dac_load_n && dac_reset_n, "R1",
          {dac_cs_n, dac_sclk, dac_load_n, dac_reset_n}, 15);
      chk(!busy && !done, "R1", {busy, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      issue_reset(1'b1, 1'b0);               // R9 mid-scale reset
      send(2'd0, 12'h123, 1);                // R5 channel A
      send(2'd1, 12'hFFF, 3);                // R5 channel B, wider half-period
      send(2'd2, 12'h000, 0);                // R6 zero divider acts as one
      send(2'd3, 12'hA5A, 2);                // R5 channel D
      send(2'd2, 12'h5A5, 1);                // R5 channel C overwrite
      issue_reset(1'b0, 1'b1);               // R9 zero reset, select flips during pulse

      // R7 request during busy is dropped
      fork
         send(2'd1, 12'h321, 2);
         begin
            repeat (6) @(negedge clk);
            req_chan = 2'd3;
            req_code = 12'hABC;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
         end
      join
      chk(m_reg[3] == exp_reg[3], "R7", m_reg[3], exp_reg[3]);

      // R6 divider change mid-frame has no effect
      fork
         send(2'd0, 12'h7E1, 2);
         begin
            repeat (8) @(negedge clk);
            cfg_half = 8'd7;
         end
      join

      // R10 reset pulse overlapping the shift phase of a frame
      fork
         send(2'd2, 12'h9C3, 2);
         begin
            repeat (20) @(negedge clk);
            issue_reset(1'b1, 1'b0);
         end
      join
      chk(m_reg[2] == 12'h9C3, "R10", m_reg[2], 12'h9C3);
      chk(m_reg[0] == 12'h800 && m_reg[1] == 12'h800 && m_reg[3] == 12'h800,
          "R10", m_reg[0], 12'h800);

      // R11 back-to-back frames each carry a full load pulse
      send(2'd3, 12'h001, 1);
      send(2'd0, 12'hFFE, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule